// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two 8-bit buses, A and B, and moves data between them in either direction. Each direction has its own storage register, loaded on the rising edge of its own load strobe. A per-direction source select picks whether the receiving bus gets the sending bus's live value or the value held in that direction's register. One active-low enable and one direction input decide which bus, if any, is driven.

The bidirectional pins appear as a separate input, output value and drive-enable for each bus, so an external pad or tristate stage can merge them. Both strobes and all controls are sampled by the block clock. A strobe rising edge is seen when a sample is high and the previous sample was low. Both output values come from a register, so switching between the live and stored source changes the output only at a clock edge and never produces a glitch. A parameter inverts the data on both paths.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst` is high, both storage registers and both output value registers clear to zero. After reset, an output on the stored source reads 0 (or all ones when inverted) until a load happens.
- R2: The A-to-B register takes `a_in` at a clock edge where `ld_ab` is sampled high after being sampled low at the previous edge. At any other edge it holds its value.
- R3: The B-to-A register takes `b_in` at a clock edge where `ld_ba` is sampled high after being sampled low at the previous edge. At any other edge it holds its value.
- R4: At each clock edge, `b_out` takes `a_in` when `ab_src` is 0 (live) and the A-to-B register's value before that edge when `ab_src` is 1 (stored).
- R5: At each clock edge, `a_out` takes `b_in` when `ba_src` is 0 and the B-to-A register's value before that edge when `ba_src` is 1.
- R6: With `en_n` low, `dir_a2b` = 1 gives `b_drv` = 1 and `a_drv` = 0, and `dir_a2b` = 0 gives `a_drv` = 1 and `b_drv` = 0. The enables follow the inputs combinationally, and the two enables are never high together.
- R7: With `en_n` high, `a_drv` and `b_drv` are both 0, and loads still happen as in R2 and R3.
- R8: With the stored source selected for two edges in a row and the register unchanged, the output value stays constant.
- R9: With parameter `INVERT` = 1, both output values are the bitwise complement of the values given in R4 and R5.
- R10: Reset has no effect on `a_drv` and `b_drv`. They follow R6 and R7 while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples strobes and controls |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 8 | Value seen on bus A |
| b_in | input | 8 | Value seen on bus B |
| ld_ab | input | 1 | Load strobe for the A-to-B register (rising edge) |
| ld_ba | input | 1 | Load strobe for the B-to-A register (rising edge) |
| ab_src | input | 1 | B output source: 0 live A, 1 stored |
| ba_src | input | 1 | A output source: 0 live B, 1 stored |
| en_n | input | 1 | Active-low output enable |
| dir_a2b | input | 1 | 1: drive B from A; 0: drive A from B |
| a_out | output | 8 | Value to drive onto bus A |
| a_drv | output | 1 | Drive enable for bus A |
| b_out | output | 8 | Value to drive onto bus B |
| b_drv | output | 1 | Drive enable for bus B |

## Verification
The hardest case to reach is a load made while both outputs are disabled, checked later through the stored source. A load strobe held high across reset is also hard to reach. It must not produce a spurious load after reset is released, because no rising edge is seen. The random stimulus toggles the strobes independently of the enable, so loads often land while `en_n` is high. A directed sequence loads both registers with the outputs disabled, then turns each path on with the stored source selected. A second directed sequence holds a strobe high through reset. A second instance with inversion enabled runs on the same inputs so that both polarities are checked in the same cycles.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
    localparam int BUS_W  = 8;
    localparam int N_PATH = 2;
    localparam int P_AB   = 0;
    localparam int P_BA   = 1;

    typedef logic [BUS_W-1:0] bus_t;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_e;

    typedef struct packed {
        logic a_drv;
        logic b_drv;
    } drive_t;

    function automatic bus_t apply_pol(input bus_t v, input bit inv);
        return inv ? ~v : v;
    endfunction
endpackage

// File: rtl/regbus_capture.sv
module regbus_capture
    import regbus_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ld_i,
    input  bus_t d_i,
    output bus_t store_o
);
    logic ld_q;
    bus_t store_q;

    always_ff @(posedge clk) begin
        ld_q <= ld_i;
        if (rst) begin
            store_q <= '0;
        end else if (ld_i && !ld_q) begin
            store_q <= d_i;
        end
    end

    assign store_o = store_q;

    AST_LOAD_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(ld_i)) |=> (store_q == $past(d_i))); // R2
    AST_HOLD_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$rose(ld_i)) |=> $stable(store_q)); // R3
endmodule

// File: rtl/regbus_path.sv
module regbus_path
    import regbus_pkg::*;
#(
    parameter bit INVERT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  src_e src_i,
    input  bus_t live_i,
    input  bus_t stored_i,
    output bus_t q_o
);
    bus_t q;
    bus_t pick;

    always_comb begin
        unique case (src_i)
            SRC_STORED: pick = stored_i;
            default:    pick = live_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= apply_pol(pick, INVERT);
    end

    assign q_o = q;

    AST_LIVE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (src_i == SRC_LIVE) |=> (q_o == apply_pol($past(live_i), INVERT))); // R4
    AST_STORED_STEADY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && src_i == SRC_STORED && $past(src_i) == SRC_STORED
         && $stable(stored_i)) |=> $stable(q_o)); // R8
endmodule

// File: rtl/regbus_decode.sv
module regbus_decode
    import regbus_pkg::*;
(
    input  logic   en_n_i,
    input  logic   dir_a2b_i,
    output drive_t drive_o
);
    always_comb begin
        drive_o = '0;
        if (!en_n_i) begin
            drive_o.b_drv = dir_a2b_i;
            drive_o.a_drv = !dir_a2b_i;
        end
    end

    always_comb begin
        AST_ONE_DRIVER: assert ($onehot0({drive_o.a_drv, drive_o.b_drv})); // R6
        if (en_n_i)
            AST_OFF_DISABLED: assert (!drive_o.a_drv && !drive_o.b_drv); // R7
    end
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
    import regbus_pkg::*;
#(
    parameter bit INVERT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] a_in,
    input  logic [BUS_W-1:0] b_in,
    input  logic             ld_ab,
    input  logic             ld_ba,
    input  logic             ab_src,
    input  logic             ba_src,
    input  logic             en_n,
    input  logic             dir_a2b,
    output logic [BUS_W-1:0] a_out,
    output logic             a_drv,
    output logic [BUS_W-1:0] b_out,
    output logic             b_drv
);
    bus_t   send   [N_PATH];
    bus_t   stored [N_PATH];
    bus_t   recv   [N_PATH];
    logic   ld     [N_PATH];
    src_e   src    [N_PATH];
    drive_t drive;

    assign send[P_AB] = a_in;
    assign send[P_BA] = b_in;
    assign ld[P_AB]   = ld_ab;
    assign ld[P_BA]   = ld_ba;
    assign src[P_AB]  = src_e'(ab_src);
    assign src[P_BA]  = src_e'(ba_src);

    for (genvar p = 0; p < N_PATH; p++) begin : g_path
        regbus_capture u_cap (
            .clk     (clk),
            .rst     (rst),
            .ld_i    (ld[p]),
            .d_i     (send[p]),
            .store_o (stored[p])
        );
        regbus_path #(.INVERT(INVERT)) u_mux (
            .clk      (clk),
            .rst      (rst),
            .src_i    (src[p]),
            .live_i   (send[p]),
            .stored_i (stored[p]),
            .q_o      (recv[p])
        );
    end

    regbus_decode u_dec (
        .en_n_i    (en_n),
        .dir_a2b_i (dir_a2b),
        .drive_o   (drive)
    );

    assign b_out = recv[P_AB];
    assign a_out = recv[P_BA];
    assign a_drv = drive.a_drv;
    assign b_drv = drive.b_drv;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (a_out == '0 && b_out == '0)); // R1
    AST_STORED_BA: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ba_src && $past(ba_src) && $stable(stored[P_BA]))
        |=> $stable(a_out)); // R5
endmodule

// File: tb/regbus_xcvr_bench.sv
module regbus_xcvr_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 3000;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] a_in, b_in;
    logic       ld_ab, ld_ba, ab_src, ba_src, en_n, dir_a2b;
    logic [7:0] a_out, b_out, ia_out, ib_out;
    logic       a_drv, b_drv, ia_drv, ib_drv;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_st_ab, m_st_ba, m_a, m_b;
    logic       m_pab, m_pba;

    always #(CLK_PERIOD/2) clk = ~clk;

    regbus_xcvr u_regbus_xcvr (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ld_ab(ld_ab), .ld_ba(ld_ba), .ab_src(ab_src), .ba_src(ba_src),
        .en_n(en_n), .dir_a2b(dir_a2b),
        .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv)
    );

    regbus_xcvr #(.INVERT(1'b1)) u_inv (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ld_ab(ld_ab), .ld_ba(ld_ba), .ab_src(ab_src), .ba_src(ba_src),
        .en_n(en_n), .dir_a2b(dir_a2b),
        .a_out(ia_out), .a_drv(ia_drv), .b_out(ib_out), .b_drv(ib_drv)
    );

    function automatic logic exp_a_drv(input logic e, input logic d);
        return !e && !d;
    endfunction
    function automatic logic exp_b_drv(input logic e, input logic d);
        return !e && d;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_drives(input string req);
        #1;
        chk(req, {6'd0, a_drv, b_drv}, {6'd0, exp_a_drv(en_n, dir_a2b), exp_b_drv(en_n, dir_a2b)});
        chk("R9", {6'd0, ia_drv, ib_drv}, {6'd0, a_drv, b_drv});
    endtask

    // One clock edge: model update from the inputs held across it, then compare.
    task automatic tick(input bit full);
        @(posedge clk);
        #2;
        if (rst) begin
            m_a = '0; m_b = '0; m_st_ab = '0; m_st_ba = '0;
        end else begin
            m_b = ab_src ? m_st_ab : a_in;
            m_a = ba_src ? m_st_ba : b_in;
            if (ld_ab && !m_pab) m_st_ab = a_in;
            if (ld_ba && !m_pba) m_st_ba = b_in;
        end
        m_pab = ld_ab;
        m_pba = ld_ba;
        if (full || b_drv) begin
            chk("R4", b_out, m_b);
            chk("R9", ib_out, rst ? 8'h00 : ~m_b);
        end
        if (full || a_drv) begin
            chk("R5", a_out, m_a);
            chk("R9", ia_out, rst ? 8'h00 : ~m_a);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; a_in = 8'h00; b_in = 8'h00;
        ld_ab = 1'b1; ld_ba = 1'b0; ab_src = 1'b1; ba_src = 1'b1;
        en_n = 1'b0; dir_a2b = 1'b1;
        m_pab = 1'b1; m_pba = 1'b0;
        m_st_ab = '0; m_st_ba = '0; m_a = '0; m_b = '0;
        check_drives("R10");
        dir_a2b = 1'b0; check_drives("R10");
        en_n = 1'b1;    check_drives("R10");
        tick(1'b1); tick(1'b1);
        chk("R1", a_out, 8'h00);
        chk("R1", b_out, 8'h00);
        // ld_ab held high through reset: no rise, no load (R2)
        rst = 1'b0; a_in = 8'hA5; b_in = 8'h3C;
        tick(1'b1); tick(1'b1); tick(1'b1);
        chk("R2", b_out, 8'h00);
        chk("R1", ia_out, 8'hFF);
        // load both while disabled (R7), then read stored
        ld_ab = 1'b0; tick(1'b1);
        ld_ab = 1'b1; ld_ba = 1'b1; tick(1'b1);
        a_in = 8'h11; b_in = 8'h22; ld_ab = 1'b0; ld_ba = 1'b0;
        check_drives("R7");
        tick(1'b1); tick(1'b1);
        chk("R7", b_out, 8'hA5);
        chk("R3", a_out, 8'h3C);
        en_n = 1'b0; dir_a2b = 1'b1; check_drives("R6");
        tick(1'b0);
        chk("R8", b_out, 8'hA5);
        dir_a2b = 1'b0; check_drives("R6");
        ab_src = 1'b0; ba_src = 1'b0; tick(1'b0);
        chk("R5", a_out, 8'h22);
        chk("R4", b_out, 8'h11);
        for (int i = 0; i < N_RAND; i++) begin
            a_in    = 8'($urandom);
            b_in    = 8'($urandom);
            ld_ab   = 1'($urandom);
            ld_ba   = 1'($urandom);
            ab_src  = 1'($urandom);
            ba_src  = 1'($urandom);
            en_n    = ($urandom % 4) == 0;
            dir_a2b = 1'($urandom);
            rst     = ($urandom % 200) == 0;
            check_drives(rst ? "R10" : "R6");
            tick(1'b0);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule